// File: doc/BRIEF.md
# Multiplexed Fan Tachometer Monitor

This block watches the speed of several fans using a single shared pulse counter. A selector routes one synchronized tachometer input at a time to the counter. The counter accumulates that fan's rising edges over a fixed window of `WINDOW_CYCLES` system clocks. At the end of the window the total is written into that fan's result register, and the selector moves to the next fan. After the last fan it wraps back to fan 0. A complete refresh of all fans therefore takes `NUM_FANS` windows.

Each fan has a programmable low-speed threshold. When a fan's finished count is strictly below its threshold, a sticky alarm flag for that fan is set. A per-fan enable mask decides which flags drive the single interrupt output. All state is reached through a plain register port. Writes take effect on the next clock edge, and reads are combinational. Results are stored registers rather than a stream, so the block has no valid/ready handshake and no back-pressure: software may read at any time and always sees the most recent complete window. `NUM_FANS` must be at least 4, and `DATA_W` must be at least `NUM_FANS` and at least `CNT_W`.

Top module: `fan_tach_mon`

## Requirements
- R1: While fan f is selected, only rising edges on `tach_in[f]` are counted. Edges on every other tachometer input during that window have no effect on any result.
- R2: A window lasts exactly `WINDOW_CYCLES` clocks. The first window starts on the first clock after reset is released. The stored result equals the number of rising edges (each high and low phase at least two clocks long) seen on the selected input during the window.
- R3: Fans are measured in the order 0, 1, …, `NUM_FANS`-1, then 0 again. Each fan's result register is overwritten once per round, at the end of its own window.
- R4: The counter saturates at 2^`CNT_W`-1 instead of wrapping.
- R5: The bit for fan f in the valid register is 0 until fan f's first window completes. It is set at that moment and stays set.
- R6: At the end of fan f's window, its alarm flag is set if the count is strictly less than threshold[f]. A count equal to the threshold sets no flag, and a threshold of 0 never raises an alarm.
- R7: Alarm flags are sticky. Writing 1 to a bit of the flag register clears that flag, and writing 0 leaves it unchanged. A new alarm in the same cycle wins over the clear.
- R8: `irq` is 1 exactly when some flag bit and the matching mask bit are both 1.
- R9: Register map, with address = {kind[1:0], index[FAN_W-1:0]}:
  - kind 0: result of fan `index` (read only).
  - kind 1: threshold of fan `index` (read/write, low `CNT_W` bits).
  - kind 2, index 0: valid vector.
  - kind 2, index 1: flag vector (write 1 to clear).
  - kind 2, index 2: interrupt mask (read/write).
  - All other addresses read 0.
- R10: After reset, all results, thresholds, valid bits, flags and mask bits are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_in | input | NUM_FANS | Asynchronous tachometer inputs, one per fan |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | FAN_W+2 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | FAN_W+2 | Read address |
| rd_data | output | DATA_W | Combinational read data |
| irq | output | 1 | Masked alarm interrupt |

## Verification
While each fan is being measured, the bench also pulses the next fan's input. A selector that leaked other inputs into the counter would therefore report inflated counts. Stimulus covers a window with no pulses, a count exactly equal to the threshold, a zero threshold, and a burst long enough to overflow a narrow counter. These catch an off-by-one compare, a wrapping counter, and a zero threshold treated as live. The bench walks valid bits one window at a time, which exposes a scan that skips or repeats fans. It then clears flags selectively and masks them, which exposes clears that leak into other bits or an interrupt that ignores the mask. A second round lets a recovered fan overwrite its old result without re-flagging, while a fan that stays stalled raises its flag again.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  typedef enum logic [1:0] {
    KIND_COUNT  = 2'd0,
    KIND_THRESH = 2'd1,
    KIND_STATUS = 2'd2,
    KIND_NONE   = 2'd3
  } reg_kind_e;

  localparam int STAT_VALID = 0;
  localparam int STAT_FLAGS = 1;
  localparam int STAT_MASK  = 2;
endpackage

// File: rtl/fan_tach_edge.sv
module fan_tach_edge #(
  parameter int NUM_FANS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FANS-1:0] tach_in,
  output logic [NUM_FANS-1:0] rise_o
);
  for (genvar g = 0; g < NUM_FANS; g++) begin : g_lane
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= tach_in[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise_o[g] = sync_q & ~prev_q;
  end
endmodule

// File: rtl/fan_tach_seq.sv
module fan_tach_seq #(
  parameter int NUM_FANS      = 8,
  parameter int CNT_W         = 16,
  parameter int WINDOW_CYCLES = 200_000_000,
  parameter int FAN_W         = $clog2(NUM_FANS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FANS-1:0] rise_i,
  output logic                done_o,
  output logic [FAN_W-1:0]    fan_o,
  output logic [CNT_W-1:0]    count_o
);
  localparam int TW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [TW-1:0]    TMR_LAST = TW'(WINDOW_CYCLES - 1);
  localparam logic [FAN_W-1:0] LAST_FAN = FAN_W'(NUM_FANS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [TW-1:0]    tmr_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [FAN_W-1:0] sel_q;
  logic             edge_sel, last;

  always_comb begin
    edge_sel = rise_i[sel_q];
    cnt_nxt  = (edge_sel && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
    last     = (tmr_q == TMR_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q <= '0;
      cnt_q <= '0;
      sel_q <= '0;
    end else if (last) begin
      tmr_q <= '0;
      cnt_q <= '0;
      sel_q <= (sel_q == LAST_FAN) ? '0 : sel_q + 1'b1;
    end else begin
      tmr_q <= tmr_q + 1'b1;
      cnt_q <= cnt_nxt;
    end
  end

  assign done_o  = last;
  assign fan_o   = sel_q;
  assign count_o = cnt_nxt;

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q <= LAST_FAN); // R3
  AST_SCAN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> fan_o == (($past(fan_o) == LAST_FAN) ? '0 : $past(fan_o) + 1'b1)); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !done_o) |=> cnt_q == CNT_MAX); // R4
endmodule

// File: rtl/fan_tach_bank.sv
module fan_tach_bank #(
  parameter int NUM_FANS = 8,
  parameter int CNT_W    = 16,
  parameter int FAN_W    = $clog2(NUM_FANS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done_i,
  input  logic [FAN_W-1:0]    fan_i,
  input  logic [CNT_W-1:0]    count_i,
  input  logic                thr_we_i,
  input  logic [FAN_W-1:0]    thr_idx_i,
  input  logic [CNT_W-1:0]    thr_val_i,
  input  logic                clr_we_i,
  input  logic [NUM_FANS-1:0] clr_bits_i,
  output logic [CNT_W-1:0]    result_o [NUM_FANS],
  output logic [CNT_W-1:0]    thr_o    [NUM_FANS],
  output logic [NUM_FANS-1:0] valid_o,
  output logic [NUM_FANS-1:0] flag_o
);
  logic [CNT_W-1:0]    result_q [NUM_FANS];
  logic [CNT_W-1:0]    thr_q    [NUM_FANS];
  logic [NUM_FANS-1:0] valid_q, flag_q, flag_nxt;
  logic                slow;

  always_comb begin
    slow     = done_i && (count_i < thr_q[fan_i]);
    flag_nxt = clr_we_i ? (flag_q & ~clr_bits_i) : flag_q;
    if (slow) flag_nxt[fan_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_FANS; i++) begin
        result_q[i] <= '0;
        thr_q[i]    <= '0;
      end
      valid_q <= '0;
      flag_q  <= '0;
    end else begin
      if (done_i) begin
        result_q[fan_i] <= count_i;
        valid_q[fan_i]  <= 1'b1;
      end
      if (thr_we_i) thr_q[thr_idx_i] <= thr_val_i;
      flag_q <= flag_nxt;
    end
  end

  assign result_o = result_q;
  assign thr_o    = thr_q;
  assign valid_o  = valid_q;
  assign flag_o   = flag_q;

  AST_VALID_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (valid_q & $past(valid_q)) == $past(valid_q)); // R5
  AST_SLOW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && (count_i < thr_q[fan_i])) |=> flag_q[$past(fan_i)]); // R6
  AST_ZERO_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && thr_q[fan_i] == '0 && !flag_q[fan_i]) |=> !flag_q[$past(fan_i)]); // R6
endmodule

// File: rtl/fan_tach_mon.sv
module fan_tach_mon #(
  parameter int NUM_FANS      = 8,
  parameter int CNT_W         = 16,
  parameter int DATA_W        = 16,
  parameter int WINDOW_CYCLES = 200_000_000,
  parameter int FAN_W         = $clog2(NUM_FANS),
  parameter int AW            = FAN_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FANS-1:0] tach_in,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq
);
  import fan_tach_pkg::*;

  logic [NUM_FANS-1:0] rise;
  logic                done;
  logic [FAN_W-1:0]    fan_sel;
  logic [CNT_W-1:0]    count;
  logic [CNT_W-1:0]    result [NUM_FANS];
  logic [CNT_W-1:0]    thr    [NUM_FANS];
  logic [NUM_FANS-1:0] valid, flags, mask_q;
  reg_kind_e           wr_kind, rd_kind;
  logic [FAN_W-1:0]    wr_idx, rd_idx;
  logic                thr_we, clr_we, mask_we, wr_unused;

  fan_tach_edge #(.NUM_FANS(NUM_FANS)) u_edge (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .rise_o(rise));

  fan_tach_seq #(.NUM_FANS(NUM_FANS), .CNT_W(CNT_W),
                 .WINDOW_CYCLES(WINDOW_CYCLES), .FAN_W(FAN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .rise_i(rise),
    .done_o(done), .fan_o(fan_sel), .count_o(count));

  always_comb begin
    wr_kind = reg_kind_e'(wr_addr[AW-1 -: 2]);
    wr_idx  = wr_addr[FAN_W-1:0];
    thr_we  = wr_en && wr_kind == KIND_THRESH;
    clr_we  = wr_en && wr_kind == KIND_STATUS && wr_idx == FAN_W'(STAT_FLAGS);
    mask_we = wr_en && wr_kind == KIND_STATUS && wr_idx == FAN_W'(STAT_MASK);
  end
  assign wr_unused = ^wr_data;

  fan_tach_bank #(.NUM_FANS(NUM_FANS), .CNT_W(CNT_W), .FAN_W(FAN_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .done_i(done), .fan_i(fan_sel), .count_i(count),
    .thr_we_i(thr_we), .thr_idx_i(wr_idx), .thr_val_i(wr_data[CNT_W-1:0]),
    .clr_we_i(clr_we), .clr_bits_i(wr_data[NUM_FANS-1:0]),
    .result_o(result), .thr_o(thr), .valid_o(valid), .flag_o(flags));

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wr_data[NUM_FANS-1:0];
  end

  assign irq = |(flags & mask_q);

  always_comb begin
    rd_kind = reg_kind_e'(rd_addr[AW-1 -: 2]);
    rd_idx  = rd_addr[FAN_W-1:0];
    rd_data = '0;
    unique case (rd_kind)
      KIND_COUNT:  rd_data = DATA_W'(result[rd_idx]);
      KIND_THRESH: rd_data = DATA_W'(thr[rd_idx]);
      KIND_STATUS: begin
        if (rd_idx == FAN_W'(STAT_VALID))      rd_data = DATA_W'(valid);
        else if (rd_idx == FAN_W'(STAT_FLAGS)) rd_data = DATA_W'(flags);
        else if (rd_idx == FAN_W'(STAT_MASK))  rd_data = DATA_W'(mask_q);
      end
      default:     rd_data = '0;
    endcase
  end

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !done) |=> ((flags & $past(wr_data[NUM_FANS-1:0])) == '0)); // R7
endmodule

// File: tb/fan_tach_mon_bench.sv
`timescale 1ns/1ps
module fan_tach_mon_bench;
  localparam int N = 8;
  localparam int CW = 4;
  localparam int DW = 16;
  localparam int W = 128;
  localparam int AW = 5;

  localparam int PULSES [N] = '{5, 2, 0, 20, 7, 6, 15, 1};
  localparam int THRESH [N] = '{3, 4, 1, 15, 7, 7, 0, 0};
  localparam int EXPCNT [N] = '{5, 2, 0, 15, 7, 6, 15, 1};
  localparam int EXPFLG [N] = '{0, 1, 1, 0, 0, 1, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] tach = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic irq;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  fan_tach_mon #(.NUM_FANS(N), .CNT_W(CW), .DATA_W(DW), .WINDOW_CYCLES(W)) u_fan_tach_mon (
    .clk(clk), .rst_n(rst_n), .tach_in(tach), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  function automatic logic [AW-1:0] adr(int kind, int idx);
    return AW'(kind * 8 + idx);
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(logic [AW-1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic wr(logic [AW-1:0] a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulses(int f, int n, int nf, int nn);
    int m = (n > nn) ? n : nn;
    for (int k = 0; k < m; k++) begin
      @(negedge clk);
      if (k < n)  tach[f]  = 1'b1;
      if (k < nn) tach[nf] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      tach = '0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (5) @(negedge clk);
    // R10 reset state
    rd(adr(2, 0), v); check("R10 valid", v, 0);
    rd(adr(2, 1), v); check("R10 flags", v, 0);
    rd(adr(2, 2), v); check("R10 mask", v, 0);
    rd(adr(0, 3), v); check("R10 result3", v, 0);
    rd(adr(1, 2), v); check("R10 thresh2", v, 0);
    check("R10 irq", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int f = 0; f < N; f++) wr(adr(1, f), THRESH[f]);
    rd(adr(1, 4), v); check("R9 thresh4 readback", v, 7);
    rd(adr(3, 1), v); check("R9 unmapped reads 0", v, 0);

    // round 0: table walk, noise on neighbour fan checks R1
    for (int f = 0; f < N; f++) begin
      wait_cyc(f * W + 16);
      pulses(f, PULSES[f], (f + 1) % N, 3);
      wait_cyc((f + 1) * W + 1);
      rd(adr(0, f), v); check($sformatf("R2/R1/R4 count fan%0d", f), v, EXPCNT[f]);
      rd(adr(2, 1), v); check($sformatf("R6 flag fan%0d", f), (v >> f) & 1, EXPFLG[f]);
      rd(adr(2, 0), v); check($sformatf("R5/R3 valid after fan%0d", f), v, (1 << (f + 1)) - 1);
      check($sformatf("R8 irq masked fan%0d", f), int'(irq), 0);
    end
    rd(adr(2, 1), v); check("R7 sticky flags", v, 8'h26);

    wr(adr(2, 2), 8'h02);
    #1; check("R8 irq mask bit1", int'(irq), 1);
    wr(adr(2, 1), 8'h02);
    rd(adr(2, 1), v); check("R7 clear bit1 only", v, 8'h24);
    check("R8 irq after clear", int'(irq), 0);
    wr(adr(2, 2), 8'hFF);
    #1; check("R8 irq full mask", int'(irq), 1);
    wr(adr(2, 1), 8'hFF);
    rd(adr(2, 1), v); check("R7 clear all", v, 0);
    check("R8 irq none", int'(irq), 0);

    // round 1
    wait_cyc(8 * W + 16);
    pulses(0, 5, 1, 3);
    wait_cyc(9 * W + 16);
    pulses(1, 9, 2, 3);
    wait_cyc(10 * W + 1);
    rd(adr(0, 1), v); check("R3 fan1 overwritten", v, 9);
    rd(adr(2, 1), v); check("R6 recovered fan no flag", v, 0);
    rd(adr(0, 2), v); check("R3 fan2 untouched", v, 0);
    wait_cyc(11 * W + 1);
    rd(adr(2, 1), v); check("R6 stalled fan2 reflags", v, 8'h04);
    check("R8 irq reasserts", int'(irq), 1);
    rd(adr(2, 0), v); check("R5 valid held", v, 8'hFF);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule